// File: doc/BRIEF.md
# SPI Pause Qualifier

This block sits between the raw pins of an SPI slave port and the slave's command engine. It brings chip select, serial clock and the active-low pause request into the system clock domain. From them it produces the state that freezes an ongoing transfer without deselecting the slave. While the pause state is active, the command engine receives no serial clock strobes, so its bit counter and shift registers hold their contents. The serial output is also forced to high impedance.

Pause entry and pause exit only ever happen while the synchronised serial clock is low. If the pause request changes while the clock is high, the change waits for the next clock-low phase. The falling clock edge that completes a bit before a deferred entry is still passed on. The falling edge that ends a deferred exit belongs to the paused interval and is dropped. As a result, when the pause ends the engine resumes on the same bit it was driving before, and no clock edge is lost or counted twice. Deselecting the slave always clears the pause and emits a deselect strobe, which ends the current operation.

Top module: `spi_pause_qualifier`

## Requirements
- R1: While reset is low and afterwards with chip select high, pause_active is 0, so_hiz is 1, sel_active is 0 and no strobe is active.
- R2: With chip select low and the synchronised serial clock low, a low pause request sets pause_active. pause_active reads 1 on the SYNC_STAGES+1-th clock after the pins change and still reads 0 one clock earlier.
- R3: A pause request that falls while the serial clock is high leaves pause_active at 0 until the serial clock has been low for one synchronised sample. After that sample, pause_active becomes 1.
- R4: A pause request that rises while the serial clock is low clears pause_active within SYNC_STAGES+1 clocks.
- R5: A pause request that rises while the serial clock is high keeps pause_active at 1 until the serial clock is next sampled low.
- R6: While pause_active is 1, sclk_rise_ev and sclk_fall_ev stay 0 whatever the serial clock does, and so_hiz is 1.
- R7: A synchronised rise of chip select (1 = deselected) gives one single-cycle desel_ev pulse and clears pause_active on the following clock. A synchronised fall gives one single-cycle sel_start_ev pulse.
- R8: While chip select is high, the pause request has no effect: pause_active stays 0 and no serial clock strobe is produced.
- R9: Each synchronised serial clock transition that occurs while the slave is selected and not paused gives exactly one one-cycle strobe: sclk_rise_ev for a 0 to 1 change, sclk_fall_ev for a 1 to 0 change. The falling edge that starts a deferred pause is passed on. The falling edge that ends a deferred exit is not.
- R10: so_hiz is 1 whenever the slave is deselected or paused, and 0 when the slave is selected and not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_pin | input | 1 | Raw chip select, active low, asynchronous |
| sclk_pin | input | 1 | Raw serial clock, asynchronous |
| pause_n_pin | input | 1 | Raw pause request, active low, asynchronous |
| sel_active | output | 1 | Synchronised chip select is asserted |
| sel_start_ev | output | 1 | One-cycle strobe when the slave becomes selected |
| desel_ev | output | 1 | One-cycle strobe when the slave becomes deselected |
| sclk_rise_ev | output | 1 | Qualified serial clock rising-edge strobe |
| sclk_fall_ev | output | 1 | Qualified serial clock falling-edge strobe |
| pause_active | output | 1 | Pause state, freezes the command engine |
| so_hiz | output | 1 | Force the serial output to high impedance |

## Verification
The hardest situations to reach are the two deferred transitions. The pause request has to change while the synchronised serial clock is high and then hold still across the next falling edge, and the edge that gets passed on or dropped there is the one most likely to be lost or counted twice. The stimulus produces these cases on purpose: it raises the serial clock, waits several clocks, toggles the pause request, and only then lowers the clock, in both the entry and the exit direction, while counting strobes. A long random phase then mixes slow serial clock toggles with rare pause and chip select changes, so that all phase combinations occur against the cycle model.

// File: rtl/pq_pkg.sv
`timescale 1ns/1ps
package pq_pkg;

  // Synchronised view of the three pins.
  typedef struct packed {
    logic sel_n;    // 1 = deselected
    logic sclk;     // serial clock level
    logic pause_n;  // 0 = pause requested
  } pq_pins_t;

  localparam int       PINS_W    = $bits(pq_pins_t);
  // Idle levels: deselected, clock low, no pause request.
  localparam pq_pins_t PINS_IDLE = pq_pins_t'(3'b101);

  // Next pause state: deselect clears, a low clock follows the request,
  // a high clock keeps the current state until the next low phase.
  function automatic logic pause_next(input pq_pins_t s, input logic cur);
    if (s.sel_n) return 1'b0;
    if (!s.sclk) return ~s.pause_n;
    return cur;
  endfunction

  // Level change from was_v to now_v going upward.
  function automatic logic went_high(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

endpackage

// File: rtl/pq_sync.sv
`timescale 1ns/1ps
module pq_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/pq_edge.sv
`timescale 1ns/1ps
module pq_edge import pq_pkg::*; #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic block,
  output logic rise,
  output logic fall
);

  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= RST_LVL;
    else        lvl_d <= lvl;
  end

  assign rise = went_high(lvl, lvl_d) & ~block;
  assign fall = went_high(lvl_d, lvl) & ~block;

  // R9: a strobe never lasts two cycles
  assert_single_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  assert_single_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/pq_pause_ctrl.sv
`timescale 1ns/1ps
module pq_pause_ctrl import pq_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  pq_pins_t pins_s,
  output logic     pause_q
);

  logic pause_d;
  logic pause_enter;
  logic pause_exit;

  always_comb pause_d = pause_next(pins_s, pause_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pause_q <= 1'b0;
    else        pause_q <= pause_d;
  end

  // Named events for the checks below.
  assign pause_enter = pause_d & ~pause_q;
  assign pause_exit  = pause_q & ~pause_d;

  // R2: request seen with clock low while selected enters pause
  assert_enter_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_s.sel_n && !pins_s.sclk && !pins_s.pause_n) |=> pause_q);
  // R3: no entry while the clock is high
  assert_no_entry_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_q && pins_s.sclk) |=> !pause_q);
  // R4: released request with clock low leaves pause
  assert_exit_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_s.sclk && pins_s.pause_n) |=> !pause_q);
  // R5: no exit while selected with the clock high
  assert_no_exit_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_q && pins_s.sclk && !pins_s.sel_n) |=> pause_q);
  // R7: deselect during pause ends it
  assert_desel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_q && pins_s.sel_n) |=> !pause_q);
  // R8: request ignored while deselected
  assert_ignored_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s.sel_n |=> !pause_q);
  // R3 / R5: transitions happen only from a clock-low sample
  assert_enter_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pause_enter |-> (!pins_s.sclk && !pins_s.sel_n));
  assert_exit_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pause_exit |-> (!pins_s.sclk || pins_s.sel_n));

endmodule

// File: rtl/spi_pause_qualifier.sv
`timescale 1ns/1ps
module spi_pause_qualifier import pq_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_pin,
  input  logic sclk_pin,
  input  logic pause_n_pin,
  output logic sel_active,
  output logic sel_start_ev,
  output logic desel_ev,
  output logic sclk_rise_ev,
  output logic sclk_fall_ev,
  output logic pause_active,
  output logic so_hiz
);

  logic [PINS_W-1:0] pins_raw;
  logic [PINS_W-1:0] pins_sync;
  pq_pins_t          pins_s;
  logic              pause_q;
  logic              sclk_block;

  assign pins_raw = {sel_n_pin, sclk_pin, pause_n_pin};

  pq_sync #(
    .WIDTH  (PINS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pins_raw),
    .d_sync (pins_sync)
  );

  assign pins_s = pq_pins_t'(pins_sync);

  pq_pause_ctrl u_pause (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_s (pins_s),
    .pause_q(pause_q)
  );

  // Serial clock edges pass only while selected and not paused.
  assign sclk_block = pause_q | pins_s.sel_n;

  pq_edge #(.RST_LVL(1'b0)) u_sclk_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (pins_s.sclk),
    .block(sclk_block),
    .rise (sclk_rise_ev),
    .fall (sclk_fall_ev)
  );

  pq_edge #(.RST_LVL(1'b1)) u_sel_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (pins_s.sel_n),
    .block(1'b0),
    .rise (desel_ev),
    .fall (sel_start_ev)
  );

  assign sel_active   = ~pins_s.sel_n;
  assign pause_active = pause_q;
  assign so_hiz       = pins_s.sel_n | pause_q;

  // R6: the engine sees no clock edge during pause
  assert_no_edge_paused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pause_active |-> !(sclk_rise_ev || sclk_fall_ev));
  // R6: output released during pause
  assert_hiz_paused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pause_active |-> so_hiz);
  // R7: deselect strobe is followed by a cleared pause
  assert_desel_then_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desel_ev |=> !pause_active);
  // R7: select and deselect strobes never coincide
  assert_sel_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_start_ev, desel_ev}));
  // R8: no clock strobe while deselected
  assert_no_edge_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |-> !(sclk_rise_ev || sclk_fall_ev));

endmodule

// File: tb/tb_spi_pause_qualifier.sv
`timescale 1ns/1ps
module tb_spi_pause_qualifier;

  localparam int S   = 2;
  localparam int LAT = S + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n_pin = 1'b1;
  logic sclk_pin = 1'b0;
  logic pause_n_pin = 1'b1;
  logic sel_active, sel_start_ev, desel_ev, sclk_rise_ev, sclk_fall_ev;
  logic pause_active, so_hiz;

  int checks = 0;
  int errors = 0;
  int rise_cnt = 0;
  int fall_cnt = 0;
  int desel_cnt = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  spi_pause_qualifier #(.SYNC_STAGES(S)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n_pin), .sclk_pin(sclk_pin),
    .pause_n_pin(pause_n_pin), .sel_active(sel_active), .sel_start_ev(sel_start_ev),
    .desel_ev(desel_ev), .sclk_rise_ev(sclk_rise_ev), .sclk_fall_ev(sclk_fall_ev),
    .pause_active(pause_active), .so_hiz(so_hiz)
  );

  // ---------------- reference model ----------------
  bit q_sel[$];
  bit q_clk[$];
  bit q_pn[$];
  bit m_sel, m_clk, m_pn;          // synchronised levels
  bit m_clk_prev, m_sel_prev;      // levels one clock earlier
  bit m_pause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_sel.delete(); q_clk.delete(); q_pn.delete();
      for (int i = 0; i < S; i++) begin
        q_sel.push_back(1'b1); q_clk.push_back(1'b0); q_pn.push_back(1'b1);
      end
      m_sel = 1; m_clk = 0; m_pn = 1;
      m_clk_prev = 0; m_sel_prev = 1; m_pause = 0;
    end else begin
      // deselected: off; clock low: follow the request; clock high: keep
      if (m_sel)       m_pause = 0;
      else if (!m_clk) m_pause = (m_pn == 0);
      m_clk_prev = m_clk;
      m_sel_prev = m_sel;
      q_sel.push_back(sel_n_pin); q_clk.push_back(sclk_pin); q_pn.push_back(pause_n_pin);
      void'(q_sel.pop_front()); void'(q_clk.pop_front()); void'(q_pn.pop_front());
      m_sel = q_sel[0]; m_clk = q_clk[0]; m_pn = q_pn[0];
    end
  end

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit open_ch;
      open_ch = !m_sel && !m_pause;
      chk(pause_active, m_pause, "R2 R3 R4 R5 pause_active");
      chk(so_hiz, !open_ch, "R10 so_hiz");
      chk(sel_active, !m_sel, "R1 sel_active");
      chk(sclk_rise_ev, open_ch && m_clk && !m_clk_prev, "R9 sclk_rise_ev");
      chk(sclk_fall_ev, open_ch && !m_clk && m_clk_prev, "R9 sclk_fall_ev");
      chk(desel_ev, m_sel && !m_sel_prev, "R7 desel_ev");
      chk(sel_start_ev, !m_sel && m_sel_prev, "R7 sel_start_ev");
    end
  end

  // Strobe counters (sampled before the edge updates them).
  always @(posedge clk) begin
    if (rst_n) begin
      if (sclk_rise_ev) rise_cnt++;
      if (sclk_fall_ev) fall_cnt++;
      if (desel_ev)     desel_cnt++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zero_counts();
    rise_cnt = 0; fall_cnt = 0; desel_cnt = 0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    step(3);
    chk(pause_active, 1'b0, "R1 pause_active in reset");
    chk(so_hiz, 1'b1, "R1 so_hiz in reset");
    rst_n = 1'b1;
    cmp_on = 1;
    step(4);
    chk(sel_active, 1'b0, "R1 sel_active after reset");
    chk(sclk_rise_ev | sclk_fall_ev | desel_ev | sel_start_ev, 1'b0, "R1 strobes idle");

    // Select and run a plain byte.
    sel_n_pin = 1'b0;
    step(6);
    chk(so_hiz, 1'b0, "R10 driving when selected");
    zero_counts();
    for (int b = 0; b < 8; b++) begin
      sclk_pin = 1'b1; step(4);
      sclk_pin = 1'b0; step(4);
    end
    step(4);
    chk_int(rise_cnt, 8, "R9 rise count byte");
    chk_int(fall_cnt, 8, "R9 fall count byte");

    // Immediate entry with clock low, latency check.
    pause_n_pin = 1'b0;
    step(LAT - 1);
    chk(pause_active, 1'b0, "R2 not yet paused");
    step(1);
    chk(pause_active, 1'b1, "R2 paused after latency");
    chk(so_hiz, 1'b1, "R6 hiz in pause");

    // Clock toggles ignored during pause.
    zero_counts();
    for (int b = 0; b < 3; b++) begin
      sclk_pin = 1'b1; step(4);
      sclk_pin = 1'b0; step(4);
    end
    step(4);
    chk_int(rise_cnt + fall_cnt, 0, "R6 no strobes in pause");
    chk(pause_active, 1'b1, "R6 still paused");

    // Immediate exit with clock low.
    pause_n_pin = 1'b1;
    step(LAT + 1);
    chk(pause_active, 1'b0, "R4 exit with clock low");

    // Deferred entry.
    zero_counts();
    sclk_pin = 1'b1; step(6);
    pause_n_pin = 1'b0; step(6);
    chk(pause_active, 1'b0, "R3 entry held while clock high");
    sclk_pin = 1'b0; step(6);
    chk(pause_active, 1'b1, "R3 entry on clock low");
    chk_int(rise_cnt, 1, "R9 rise before deferred entry");
    chk_int(fall_cnt, 1, "R9 fall completing bit passed");

    // Deferred exit.
    zero_counts();
    sclk_pin = 1'b1; step(6);
    pause_n_pin = 1'b1; step(6);
    chk(pause_active, 1'b1, "R5 exit held while clock high");
    sclk_pin = 1'b0; step(6);
    chk(pause_active, 1'b0, "R5 exit on clock low");
    chk_int(rise_cnt + fall_cnt, 0, "R9 no strobe across deferred exit");

    // Deselect during pause.
    pause_n_pin = 1'b0; step(6);
    chk(pause_active, 1'b1, "R2 paused again");
    zero_counts();
    sel_n_pin = 1'b1; step(6);
    chk(pause_active, 1'b0, "R7 deselect clears pause");
    chk_int(desel_cnt, 1, "R7 single deselect strobe");

    // Deselected: request ignored.
    zero_counts();
    for (int b = 0; b < 3; b++) begin
      sclk_pin = 1'b1; step(4);
      sclk_pin = 1'b0; step(4);
    end
    chk(pause_active, 1'b0, "R8 request ignored when deselected");
    chk_int(rise_cnt + fall_cnt, 0, "R8 no strobes when deselected");
    pause_n_pin = 1'b1;
    step(4);

    // Random mix.
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 3) == 0) sclk_pin = ~sclk_pin;
      if ($urandom_range(0, 29) == 0) pause_n_pin = ~pause_n_pin;
      if ($urandom_range(0, 99) == 0) sel_n_pin = ~sel_n_pin;
      step(1);
    end
    step(6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule